// File: doc/BRIEF.md
# Asynchronous Serial Line-Break Unit

This unit handles the line-break condition on one asynchronous serial channel and sits between a character framer and a receive FIFO. On the transmit side it can hold the serial output low while a software break command is set. The start and the end of the forced-low period are aligned to the transmit bit-clock strobe. On the receive side it examines every character that the framer delivers. A character whose data bits, optional parity bit and required stop bits were all sampled low is a break. That character is consumed and not written to the FIFO.

Once a break is seen, the unit enters a hold state and drops every further character. It also tells the framer through `rx_hold` to stay idle. It leaves the hold state when the line is observed high again, so the framer restarts on the next start bit. Break start and break end each set their own sticky status bit. Each bit has its own enable and its own clear-on-write strobe, and the enabled bits are combined into one interrupt line.

Characters reach the unit as a valid/ready stream (`ch_*`) and leave it as a valid/ready stream (`fq_*`) through one output register. A producer keeps `ch_valid` and its payload stable until a cycle in which `ch_ready` is high. The output holds `fq_valid` and `fq_data` stable until `fq_ready` accepts them. `ch_ready` is high when the output register is empty or being drained, and it is always high during hold, because characters received in hold are discarded.

Top module: `uart_brk_unit`

## Requirements
- R1: At each clock where `tx_tick` is high, the break state is loaded from `tx_brk_cmd`. From the following cycle on, `tx_ser_out` is 0 whenever that state is set.
- R2: When the break state is clear, `tx_ser_out` equals `tx_ser_in` in the same cycle. A cleared command releases the line only after the next `tx_tick` clock.
- R3: A character is a break when the following bits are all 0: its data bits below the configured length (`cfg_len` 0,1,2,3 gives 5,6,7,8 bits; higher bits are ignored), `ch_par` when `cfg_par_en` is 1, `ch_stop[0]`, and `ch_stop[1]` when `cfg_stop2` is 1.
- R4: When a break character is accepted out of hold, `rx_hold` rises in the next cycle. It stays high until a clock at which `rx_line` is 1, and it is low in the cycle after that clock.
- R5: A break character is never forwarded. Characters accepted while `rx_hold` is high are dropped.
- R6: `irq_stat[0]` (break seen) is set on detection and `irq_stat[1]` (break ended) is set on exit from hold, each in the cycle after the event. Both are sticky and cleared by a 1 on the matching `irq_clr` bit; if a set and a clear fall in the same clock, the set wins.
- R7: `irq` equals the OR of `irq_stat & irq_en`.
- R8: Each accepted character that is not a break is forwarded one cycle later. Its data is masked to the configured length, and `fq_frm_err` is 1 when any required stop bit is 0. `fq_valid` and `fq_data` hold stable while `fq_ready` is 0.
- R9: `ch_ready` is 1 when `fq_valid` is 0, when `fq_ready` is 1, or when `rx_hold` is 1.
- R10: During reset, the break states are clear, `fq_valid` is 0, `irq_stat` is 0 and `tx_ser_out` follows `tx_ser_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tx_tick | input | 1 | transmit bit-clock strobe |
| tx_brk_cmd | input | 1 | software break command level |
| tx_ser_in | input | 1 | serial data from the transmit shifter |
| tx_ser_out | output | 1 | serial line output |
| cfg_len | input | LEN_W | character length code (length = 5 + code) |
| cfg_par_en | input | 1 | parity bit present |
| cfg_stop2 | input | 1 | two stop bits |
| rx_line | input | 1 | synchronised receive line level |
| ch_valid | input | 1 | framer character valid |
| ch_ready | output | 1 | character accepted |
| ch_data | input | CHR_W | received data bits, LSB first bit |
| ch_par | input | 1 | sampled parity bit level |
| ch_stop | input | 2 | sampled stop bit levels, [0] first |
| fq_valid | output | 1 | FIFO write valid |
| fq_ready | input | 1 | FIFO can accept |
| fq_data | output | CHR_W | masked character |
| fq_frm_err | output | 1 | framing error flag of the character |
| rx_hold | output | 1 | break hold; framer held idle |
| irq_en | input | 2 | interrupt enables [0] break, [1] break ended |
| irq_clr | input | 2 | clear strobes for status bits |
| irq_stat | output | 2 | sticky status bits |
| irq | output | 1 | combined interrupt |

## Verification
The transmit output responds in the same cycle to `tx_ser_in`, and one cycle after a `tx_tick` clock to the command. Hold entry, hold exit, the status bits and a forwarded character all appear one register later, in the cycle after the clock that accepted the character or observed the line. `ch_ready` and `irq` are combinational on the present state. The bench updates a behavioural model at every rising edge from the inputs held over that edge and compares every output at the falling edge, before new inputs are driven. Each comparison therefore covers exactly the latency above.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  localparam int CHR_MAX  = 8;
  localparam int CHR_MIN  = 5;
  localparam int IRQ_N    = 2;
  localparam int IRQ_BRK  = 0;
  localparam int IRQ_BRKT = 1;

  typedef enum logic {RX_RUN = 1'b0, RX_HOLD = 1'b1} rx_state_e;
endpackage

// File: rtl/brk_tx_gen.sv
module brk_tx_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cmd,
  input  logic ser_in,
  output logic ser_out
);
  logic brk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    brk_on <= 1'b0;
    else if (tick) brk_on <= cmd;
  end

  assign ser_out = brk_on ? 1'b0 : ser_in;
endmodule

// File: rtl/brk_rx_det.sv
module brk_rx_det #(
  parameter int CHR_W = uart_brk_pkg::CHR_MAX,
  parameter int MIN_L = uart_brk_pkg::CHR_MIN,
  localparam int LEN_W = $clog2(CHR_W - MIN_L + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_stop2,
  input  logic [CHR_W-1:0] data,
  input  logic             par,
  input  logic [1:0]       stop,
  input  logic             fire,
  input  logic             line,
  output logic [CHR_W-1:0] data_m,
  output logic             is_brk,
  output logic             frm_err,
  output logic             hold,
  output logic             brk_set,
  output logic             brkt_set
);
  import uart_brk_pkg::*;

  logic [CHR_W-1:0] mask;
  rx_state_e        st_q, st_d;

  for (genvar i = 0; i < CHR_W; i++) begin : g_mask
    assign mask[i] = (i < MIN_L + int'(cfg_len));
  end

  assign data_m  = data & mask;
  assign frm_err = !stop[0] || (cfg_stop2 && !stop[1]);
  assign is_brk  = (data_m == '0) && !(cfg_par_en && par) &&
                   !stop[0] && !(cfg_stop2 && stop[1]);

  always_comb begin
    st_d     = st_q;
    brk_set  = 1'b0;
    brkt_set = 1'b0;
    unique case (st_q)
      RX_RUN: if (fire && is_brk) begin
        st_d    = RX_HOLD;
        brk_set = 1'b1;
      end
      RX_HOLD: if (line) begin
        st_d     = RX_RUN;
        brkt_set = 1'b1;
      end
      default: st_d = RX_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RX_RUN;
    else        st_q <= st_d;
  end

  assign hold = (st_q == RX_HOLD);
endmodule

// File: rtl/brk_irq_ctl.sv
module brk_irq_ctl #(
  parameter int N = uart_brk_pkg::IRQ_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] stat,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat[i] <= 1'b0;
      else if (set[i]) stat[i] <= 1'b1;
      else if (clr[i]) stat[i] <= 1'b0;
    end
  end

  assign irq = |(stat & en);
endmodule

// File: rtl/brk_out_stage.sv
module brk_out_stage #(
  parameter int CHR_W = uart_brk_pkg::CHR_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CHR_W-1:0] in_data,
  input  logic             in_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CHR_W-1:0] out_data,
  output logic             out_err,
  output logic             room
);
  assign room = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_err   <= in_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_brk_unit.sv
module uart_brk_unit #(
  parameter int CHR_W = uart_brk_pkg::CHR_MAX,
  parameter int MIN_L = uart_brk_pkg::CHR_MIN,
  localparam int LEN_W = $clog2(CHR_W - MIN_L + 1),
  localparam int NI    = uart_brk_pkg::IRQ_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_tick,
  input  logic             tx_brk_cmd,
  input  logic             tx_ser_in,
  output logic             tx_ser_out,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_stop2,
  input  logic             rx_line,
  input  logic             ch_valid,
  output logic             ch_ready,
  input  logic [CHR_W-1:0] ch_data,
  input  logic             ch_par,
  input  logic [1:0]       ch_stop,
  output logic             fq_valid,
  input  logic             fq_ready,
  output logic [CHR_W-1:0] fq_data,
  output logic             fq_frm_err,
  output logic             rx_hold,
  input  logic [NI-1:0]    irq_en,
  input  logic [NI-1:0]    irq_clr,
  output logic [NI-1:0]    irq_stat,
  output logic             irq
);
  import uart_brk_pkg::*;

  logic [CHR_W-1:0] data_m;
  logic             is_brk, frm_err, brk_set, brkt_set, room, fire, push;
  logic [NI-1:0]    set_v;

  brk_tx_gen u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .cmd(tx_brk_cmd),
    .ser_in(tx_ser_in), .ser_out(tx_ser_out)
  );

  assign ch_ready = room || rx_hold;
  assign fire     = ch_valid && ch_ready;
  assign push     = fire && !rx_hold && !is_brk;

  brk_rx_det #(.CHR_W(CHR_W), .MIN_L(MIN_L)) u_det (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_stop2(cfg_stop2), .data(ch_data), .par(ch_par), .stop(ch_stop),
    .fire(fire), .line(rx_line), .data_m(data_m), .is_brk(is_brk),
    .frm_err(frm_err), .hold(rx_hold), .brk_set(brk_set), .brkt_set(brkt_set)
  );

  brk_out_stage #(.CHR_W(CHR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .push(push), .in_data(data_m), .in_err(frm_err),
    .out_valid(fq_valid), .out_ready(fq_ready), .out_data(fq_data),
    .out_err(fq_frm_err), .room(room)
  );

  always_comb begin
    set_v           = '0;
    set_v[IRQ_BRK]  = brk_set;
    set_v[IRQ_BRKT] = brkt_set;
  end

  brk_irq_ctl #(.N(NI)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(set_v), .clr(irq_clr), .en(irq_en),
    .stat(irq_stat), .irq(irq)
  );
endmodule

// File: rtl/uart_brk_sva.sv
module uart_brk_sva #(
  parameter int CHR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_tick,
  input logic             tx_brk_cmd,
  input logic             tx_ser_in,
  input logic             tx_ser_out,
  input logic             rx_line,
  input logic             fq_valid,
  input logic             fq_ready,
  input logic [CHR_W-1:0] fq_data,
  input logic             rx_hold,
  input logic [1:0]       irq_stat,
  input logic [1:0]       irq_clr
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(tx_tick) && $past(tx_brk_cmd)) |-> !tx_ser_out);

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(tx_tick) && !$past(tx_brk_cmd)) |-> (tx_ser_out == tx_ser_in));

  a_r4_exit_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hold && rx_line) |=> (!rx_hold && irq_stat[1]));

  a_r5_no_fwd_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hold && !fq_valid) |=> !fq_valid);

  a_r6_sticky_brk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat[0] && !irq_clr[0]) |=> irq_stat[0]);

  a_r6_sticky_end: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat[1] && !irq_clr[1]) |=> irq_stat[1]);

  a_r8_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid && !fq_ready) |=> (fq_valid && $stable(fq_data)));
endmodule

bind uart_brk_unit uart_brk_sva #(.CHR_W(CHR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .tx_brk_cmd(tx_brk_cmd),
  .tx_ser_in(tx_ser_in), .tx_ser_out(tx_ser_out), .rx_line(rx_line),
  .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_data(fq_data),
  .rx_hold(rx_hold), .irq_stat(irq_stat), .irq_clr(irq_clr)
);

// File: tb/uart_brk_unit_tb.sv
module uart_brk_unit_tb;
  localparam int CLK_P  = 10;
  localparam int NCYC   = 3200;
  localparam int WD_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_tick = 0, tx_brk_cmd = 0, tx_ser_in = 1, tx_ser_out;
  logic [1:0] cfg_len = 0;
  logic       cfg_par_en = 0, cfg_stop2 = 0, rx_line = 1;
  logic       ch_valid = 0, ch_ready, ch_par = 0;
  logic [7:0] ch_data = 0;
  logic [1:0] ch_stop = 2'b11;
  logic       fq_valid, fq_ready = 0, fq_frm_err, rx_hold, irq;
  logic [7:0] fq_data;
  logic [1:0] irq_en = 0, irq_clr = 0, irq_stat;

  int  n_vec = 0, n_bad = 0;
  bit  done = 0;

  // behavioural model state
  bit       m_btx, m_hold, m_taken;
  bit [1:0] m_stat;
  bit [8:0] m_q[$];

  always #(CLK_P/2) clk = ~clk;

  uart_brk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .tx_brk_cmd(tx_brk_cmd),
    .tx_ser_in(tx_ser_in), .tx_ser_out(tx_ser_out), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2), .rx_line(rx_line),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data), .ch_par(ch_par),
    .ch_stop(ch_stop), .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_data(fq_data),
    .fq_frm_err(fq_frm_err), .rx_hold(rx_hold), .irq_en(irq_en), .irq_clr(irq_clr),
    .irq_stat(irq_stat), .irq(irq)
  );

  function automatic bit [7:0] len_mask(input int code);
    bit [7:0] m = '0;
    for (int i = 0; i < 8; i++) if (i < 5 + code) m[i] = 1'b1;
    return m;
  endfunction

  function automatic bit model_brk();
    return ((ch_data & len_mask(cfg_len)) == 0) && !(cfg_par_en && ch_par) &&
           !ch_stop[0] && !(cfg_stop2 && ch_stop[1]);
  endfunction

  function automatic bit exp_ready();
    return m_hold || (m_q.size() == 0) || fq_ready;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_btx = 0; m_hold = 0; m_stat = 0; m_taken = 0; m_q.delete();
    end else begin
      bit rdy, pop, s0, s1;
      bit [8:0] ent;
      rdy = exp_ready();
      pop = (m_q.size() > 0) && fq_ready;
      s0 = 0; s1 = 0;
      m_taken = ch_valid && rdy;
      if (tx_tick) m_btx = tx_brk_cmd;
      if (pop) void'(m_q.pop_front());
      if (m_hold) begin
        if (rx_line) begin m_hold = 0; s1 = 1; end
      end else if (ch_valid && rdy) begin
        if (model_brk()) begin m_hold = 1; s0 = 1; end
        else begin
          ent[7:0] = ch_data & len_mask(cfg_len);
          ent[8]   = !ch_stop[0] || (cfg_stop2 && !ch_stop[1]);
          m_q.push_back(ent);
        end
      end
      m_stat = (m_stat & ~irq_clr) | {s1, s0};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1/R2 tx_ser_out", tx_ser_out, m_btx ? 1'b0 : tx_ser_in);
    chk("R4 rx_hold", rx_hold, m_hold);
    chk("R5/R8 fq_valid", fq_valid, m_q.size() > 0);
    if (m_q.size() > 0) begin
      chk("R3/R8 fq_data", fq_data, m_q[0][7:0]);
      chk("R8 fq_frm_err", fq_frm_err, m_q[0][8]);
    end
    chk("R9 ch_ready", ch_ready, exp_ready());
    chk("R6 irq_stat", irq_stat, m_stat);
    chk("R7 irq", irq, |(m_stat & irq_en));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: state held in reset
    chk("R10 reset fq_valid", fq_valid, 1'b0);
    chk("R10 reset irq_stat", irq_stat, 2'b00);
    chk("R10 reset rx_hold", rx_hold, 1'b0);
    chk("R10 reset tx_ser_out", tx_ser_out, tx_ser_in);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      check_all();
      cfg_len    = 2'((cyc / 400) % 4);
      cfg_par_en = ((cyc / 1600) % 2) == 1;
      cfg_stop2  = ((cyc / 200) % 2) == 1;
      irq_en     = 2'((cyc / 300) % 4);
      tx_tick    = (cyc % 4) == 0;
      tx_brk_cmd = ((cyc / 37) % 3) == 0;
      tx_ser_in  = 1'($urandom);
      fq_ready   = ($urandom % 4) != 0;
      irq_clr    = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      rx_line    = m_hold ? (($urandom % 5) == 0) : 1'($urandom);
      if (!(ch_valid && !m_taken)) begin
        int kind = $urandom % 8;
        bit [7:0] msk = len_mask(cfg_len);
        ch_valid = ($urandom % 3) != 0;
        case (kind)
          0: begin ch_data = 8'($urandom) & ~msk; ch_par = 0; ch_stop = 2'b00; end // R3 break
          1: begin ch_data = 8'($urandom) & ~msk; ch_par = 1; ch_stop = 2'b00; end // R3 parity
          2: begin ch_data = 0; ch_par = 0; ch_stop = {1'($urandom), 1'b1}; end   // R3 stop
          3: begin ch_data = 8'($urandom) & ~msk; ch_par = 0; ch_stop = 2'b10; end // R3 2nd stop
          default: begin ch_data = 8'($urandom); ch_par = 1'($urandom); ch_stop = 2'($urandom); end
        endcase
      end
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * WD_CYC);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule